// File: doc/BRIEF.md
# Dual External-Data Pointer with Auto-Step and Auto-Swap

This block holds the two address pointers that an 8-bit controller core uses for accesses to external data memory. Each pointer is 16 bits wide by default, and each can be read and written byte by byte through a small special-register port. A select bit in the control register chooses which pointer is active. The active pointer drives the external data address output.

The core pulses `xfer_done` when it finishes an external data access. It pulses `inc_req` when it executes an increment-pointer instruction. With auto-step enabled, every access moves the pointer that served it by one. Each pointer has its own direction bit, so it steps up or down. With auto-swap enabled, every access also flips the select bit.

With both features on, a block copy needs only one instruction pair per byte: a read through pointer 0 and then a write through pointer 1. The loop needs no pointer bookkeeping at all.

Top module: `dptr_pair_unit`

## Requirements
- R1: A synchronous active-high reset clears both pointers to zero and the control register to zero, so pointer 0 is selected and auto-step and auto-swap are off. `ext_addr` reads zero from the edge that applies reset.
- R2: Register map on `reg_addr`:
  - 0 is pointer 0 low byte and 1 is pointer 0 high byte.
  - 2 is pointer 1 low byte and 3 is pointer 1 high byte.
  - 4 is control: bit0 select, bit1 auto-step enable, bit2 auto-swap enable, bit3 pointer 0 direction, bit4 pointer 1 direction (1 = down).
  - `reg_rdata` presents the addressed register one clock after the address is applied.
  - Control bits 7:5 read as 0. Addresses 5 to 7 read as 0, and writes to them have no effect.
- R3: `ext_addr` always equals the pointer picked by the select bit. It changes on the same clock edge as the pointer or select state.
- R4: With auto-step off, `xfer_done` leaves both pointers unchanged.
- R5: With auto-step on, `xfer_done` moves the active pointer by +1 if its direction bit is 0 and by -1 if it is 1. The other pointer is left unchanged.
- R6: Pointer arithmetic wraps modulo 2^16: FFFF steps up to 0000, and 0000 steps down to FFFF.
- R7: With auto-swap on, `xfer_done` inverts the select bit. The step hits the pointer that was selected before the swap.
- R8: `inc_req` adds 1 to the active pointer, whatever its direction bit or the enable bits are. It never changes the select bit.
- R9: When `xfer_done` and `inc_req` arrive in the same clock, both steps apply to the active pointer. A down-step combined with an increment leaves the pointer unchanged, and an up-step combined with an increment adds 2.
- R10: A register write takes priority over hardware updates in the same clock:
  - A byte write to a pointer cancels that pointer's step for the clock and keeps its other byte.
  - A control write sets the select bit to the written value instead of the swap. The step still uses the control value that held before the write.
- R11: In a clock with no write, no `xfer_done` and no `inc_req`, the pointers, the control register and `ext_addr` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register index for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| xfer_done | input | 1 | External data access completed (one pulse per access) |
| inc_req | input | 1 | Increment-active-pointer strobe from the core |
| ext_addr | output | PTR_W | External data address, registered |

## Verification
The assertions take every strobe to be a clean one-clock pulse. They also take the register port to carry at most one write per clock. The step and increment properties each cover only clocks in which no register write lands, and the write-priority properties cover only the clocks that carry one. The directed tasks drive each strobe for exactly one clock between falling edges. They raise `reg_wr` together with `xfer_done` or `inc_req` only in the write-priority scenario, which the bench then checks on its own.

// File: rtl/dptr_pkg.sv
package dptr_pkg;

  // Control register layout, bit 0 first from the right.
  typedef struct packed {
    logic dir1;    // bit4: pointer 1 steps down when set
    logic dir0;    // bit3: pointer 0 steps down when set
    logic swap_en; // bit2: flip select after each access
    logic step_en; // bit1: step used pointer after each access
    logic sel;     // bit0: active pointer
  } dp_ctrl_t;

  localparam int unsigned CTRL_W = $bits(dp_ctrl_t);
  localparam int unsigned NPTR   = 2;

  // Signed step amount in the range -1..+2, held in 3 bits.
  function automatic logic [2:0] step_amount(input logic auto_hit,
                                             input logic down,
                                             input logic inc_hit);
    logic [2:0] s;
    s = 3'd0;
    if (auto_hit) s = down ? 3'b111 : 3'b001;
    if (inc_hit)  s = s + 3'd1;
    return s;
  endfunction

endpackage

// File: rtl/dptr_ctrl_reg.sv
module dptr_ctrl_reg
  import dptr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              xfer_done,
  output dp_ctrl_t          ctrl_q,
  output dp_ctrl_t          ctrl_d
);

  always_comb begin
    ctrl_d = ctrl_q;
    if (xfer_done && ctrl_q.swap_en) ctrl_d.sel = ~ctrl_q.sel;
    if (wr_en) ctrl_d = dp_ctrl_t'(wdata);
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_d;
  end

endmodule

// File: rtl/dptr_slot.sv
module dptr_slot #(
  parameter int unsigned PTR_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [PTR_W/8-1:0]     byte_wr,
  input  logic [7:0]             wdata,
  input  logic                   auto_hit,
  input  logic                   down,
  input  logic                   inc_hit,
  output logic [PTR_W-1:0]       ptr_q,
  output logic [PTR_W-1:0]       ptr_d
);
  import dptr_pkg::*;

  localparam int unsigned NBYTES = PTR_W / 8;

  logic [2:0]       amt;
  logic [PTR_W-1:0] amt_ext;
  logic [PTR_W-1:0] stepped;
  logic [PTR_W-1:0] written;

  assign amt     = step_amount(auto_hit, down, inc_hit);
  assign amt_ext = {{(PTR_W-3){amt[2]}}, amt};
  assign stepped = ptr_q + amt_ext;

  genvar b;
  generate
    for (b = 0; b < NBYTES; b++) begin : g_byte
      assign written[b*8 +: 8] = byte_wr[b] ? wdata : ptr_q[b*8 +: 8];
    end
  endgenerate

  // Any byte write to this pointer suppresses the arithmetic update.
  assign ptr_d = (|byte_wr) ? written : stepped;

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else     ptr_q <= ptr_d;
  end

endmodule

// File: rtl/dptr_rd_port.sv
module dptr_rd_port #(
  parameter int unsigned PTR_W  = 16,
  parameter int unsigned REG_AW = 3
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [REG_AW-1:0]                    rd_addr,
  input  logic [dptr_pkg::NPTR-1:0][PTR_W-1:0] ptrs,
  input  dptr_pkg::dp_ctrl_t                   ctrl,
  output logic [7:0]                           rdata
);
  import dptr_pkg::*;

  localparam int unsigned NBYTES   = PTR_W / 8;
  localparam int unsigned CTRL_IDX = NPTR * NBYTES;

  logic [7:0] rd_mux;

  always_comb begin
    rd_mux = 8'h00;
    for (int p = 0; p < NPTR; p++) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (rd_addr == REG_AW'(p * NBYTES + b)) rd_mux = ptrs[p][b*8 +: 8];
      end
    end
    if (rd_addr == REG_AW'(CTRL_IDX)) rd_mux = {{(8-CTRL_W){1'b0}}, ctrl};
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= 8'h00;
    else     rdata <= rd_mux;
  end

endmodule

// File: rtl/dptr_pair_unit.sv
module dptr_pair_unit #(
  parameter int unsigned PTR_W  = 16,
  parameter int unsigned REG_AW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              xfer_done,
  input  logic              inc_req,
  output logic [PTR_W-1:0]  ext_addr
);
  import dptr_pkg::*;

  localparam int unsigned NBYTES   = PTR_W / 8;
  localparam int unsigned CTRL_IDX = NPTR * NBYTES;

  dp_ctrl_t ctrl_q;
  dp_ctrl_t ctrl_d;
  logic     ctrl_wr;
  logic [NPTR-1:0][PTR_W-1:0]  ptr_q;
  logic [NPTR-1:0][PTR_W-1:0]  ptr_d;
  logic [NPTR-1:0][NBYTES-1:0] byte_wr;
  logic [NPTR-1:0]             auto_hit;
  logic [NPTR-1:0]             inc_hit;
  logic [NPTR-1:0]             down;

  assign ctrl_wr = reg_wr && (reg_addr == REG_AW'(CTRL_IDX));

  dptr_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (ctrl_wr),
    .wdata     (reg_wdata[CTRL_W-1:0]),
    .xfer_done (xfer_done),
    .ctrl_q    (ctrl_q),
    .ctrl_d    (ctrl_d)
  );

  assign down[0] = ctrl_q.dir0;
  assign down[1] = ctrl_q.dir1;

  genvar p, b;
  generate
    for (p = 0; p < NPTR; p++) begin : g_ptr
      for (b = 0; b < NBYTES; b++) begin : g_wr
        assign byte_wr[p][b] = reg_wr && (reg_addr == REG_AW'(p * NBYTES + b));
      end
      assign auto_hit[p] = xfer_done && ctrl_q.step_en && (ctrl_q.sel == 1'(p));
      assign inc_hit[p]  = inc_req && (ctrl_q.sel == 1'(p));

      dptr_slot #(.PTR_W(PTR_W)) u_slot (
        .clk      (clk),
        .rst      (rst),
        .byte_wr  (byte_wr[p]),
        .wdata    (reg_wdata),
        .auto_hit (auto_hit[p]),
        .down     (down[p]),
        .inc_hit  (inc_hit[p]),
        .ptr_q    (ptr_q[p]),
        .ptr_d    (ptr_d[p])
      );
    end
  endgenerate

  dptr_rd_port #(.PTR_W(PTR_W), .REG_AW(REG_AW)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_addr (reg_addr),
    .ptrs    (ptr_q),
    .ctrl    (ctrl_q),
    .rdata   (reg_rdata)
  );

  // Output register loads from next state so it tracks the active pointer.
  always_ff @(posedge clk) begin
    if (rst) ext_addr <= '0;
    else     ext_addr <= ptr_d[ctrl_d.sel];
  end

endmodule

// File: rtl/dptr_pair_checker.sv
module dptr_pair_checker
  import dptr_pkg::*;
#(
  parameter int unsigned PTR_W  = 16,
  parameter int unsigned REG_AW = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic              xfer_done,
  input logic              inc_req,
  input logic [PTR_W-1:0]  ext_addr,
  input dp_ctrl_t          ctrl,
  input logic [PTR_W-1:0]  ptr0,
  input logic [PTR_W-1:0]  ptr1
);

  localparam int unsigned CTRL_IDX = 2 * (PTR_W / 8);

  logic [PTR_W-1:0] act_ptr;
  logic             act_down;
  logic [PTR_W-1:0] exp_step;

  assign act_ptr  = ctrl.sel ? ptr1 : ptr0;
  assign act_down = ctrl.sel ? ctrl.dir1 : ctrl.dir0;
  assign exp_step = act_down ? act_ptr - 1'b1 : act_ptr + 1'b1;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (ext_addr == '0 && ctrl == '0 && ptr0 == '0 && ptr1 == '0));

  a_r3_addr_tracks_sel: assert property (@(posedge clk) disable iff (rst)
    ext_addr == act_ptr);

  a_r4_no_step_when_off: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && !ctrl.step_en && !inc_req && !reg_wr)
      |=> ($stable(ptr0) && $stable(ptr1)));

  a_r5_step_used_ptr: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && ctrl.step_en && !inc_req && !reg_wr)
      |=> (($past(ctrl.sel) ? ptr1 : ptr0) == $past(exp_step)));

  a_r7_swap_flips_sel: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && ctrl.swap_en && !reg_wr) |=> (ctrl.sel != $past(ctrl.sel)));

  a_r8_inc_up: assert property (@(posedge clk) disable iff (rst)
    (inc_req && !xfer_done && !reg_wr)
      |=> (ext_addr == $past(ext_addr) + 1'b1 && $stable(ctrl)));

  a_r10_byte_write_wins: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == '0) |=> (ptr0[7:0] == $past(reg_wdata)));

  a_r10_ctrl_write_wins: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == REG_AW'(CTRL_IDX))
      |=> (ctrl == $past(reg_wdata[CTRL_W-1:0])));

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!xfer_done && !inc_req && !reg_wr)
      |=> ($stable(ext_addr) && $stable(ctrl) && $stable(ptr0) && $stable(ptr1)));

endmodule

bind dptr_pair_unit dptr_pair_checker #(.PTR_W(PTR_W), .REG_AW(REG_AW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .xfer_done (xfer_done),
  .inc_req   (inc_req),
  .ext_addr  (ext_addr),
  .ctrl      (ctrl_q),
  .ptr0      (ptr_q[0]),
  .ptr1      (ptr_q[1])
);

// File: tb/dptr_pair_unit_tb.sv
module dptr_pair_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        xfer_done = 1'b0;
  logic        inc_req = 1'b0;
  logic [15:0] ext_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dptr_pair_unit #(.PTR_W(16), .REG_AW(3)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_done(xfer_done),
    .inc_req(inc_req), .ext_addr(ext_addr)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    rd(lo, l);
    rd(lo + 3'd1, h);
    v = {h, l};
  endtask

  task automatic xfer();
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  task automatic bump();
    inc_req = 1'b1;
    @(negedge clk);
    inc_req = 1'b0;
  endtask

  task automatic set_ptrs(input logic [15:0] a, input logic [15:0] b);
    wr(3'd0, a[7:0]); wr(3'd1, a[15:8]);
    wr(3'd2, b[7:0]); wr(3'd3, b[15:8]);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 ext_addr after reset", ext_addr, 16'h0000);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk("R1 register cleared", {8'h00, d}, 16'h0000);
    end
  endtask

  task automatic t_regs();
    logic [15:0] v;
    logic [7:0] d;
    set_ptrs(16'h1234, 16'hABCD);
    rd16(3'd0, v); chk("R2 pointer0 readback", v, 16'h1234);
    rd16(3'd2, v); chk("R2 pointer1 readback", v, 16'hABCD);
    chk("R3 ext_addr follows pointer0", ext_addr, 16'h1234);
    wr(3'd4, 8'h01);
    chk("R3 ext_addr follows pointer1", ext_addr, 16'hABCD);
    wr(3'd4, 8'hFF);
    rd(3'd4, d); chk("R2 control upper bits zero", {8'h00, d}, 16'h001F);
    wr(3'd5, 8'h77);
    rd(3'd5, d); chk("R2 unmapped address reads zero", {8'h00, d}, 16'h0000);
    chk("R2 unmapped write no effect", ext_addr, 16'hABCD);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_step_off();
    xfer();
    chk("R4 access with auto-step off", ext_addr, 16'h1234);
    repeat (3) @(negedge clk);
    chk("R11 idle holds", ext_addr, 16'h1234);
  endtask

  task automatic t_step();
    logic [15:0] v;
    wr(3'd4, 8'h02);
    xfer();
    chk("R5 pointer0 steps up", ext_addr, 16'h1235);
    rd16(3'd2, v); chk("R5 pointer1 untouched", v, 16'hABCD);
    wr(3'd4, 8'h13);
    xfer();
    chk("R5 pointer1 steps down", ext_addr, 16'hABCC);
    rd16(3'd0, v); chk("R5 pointer0 untouched", v, 16'h1235);
  endtask

  task automatic t_wrap();
    set_ptrs(16'hFFFF, 16'h0000);
    wr(3'd4, 8'h02);
    xfer();
    chk("R6 wrap up", ext_addr, 16'h0000);
    wr(3'd4, 8'h13);
    xfer();
    chk("R6 wrap down", ext_addr, 16'hFFFF);
  endtask

  task automatic t_swap();
    logic [15:0] v;
    logic [7:0] d;
    set_ptrs(16'h1000, 16'h2000);
    wr(3'd4, 8'h06);
    xfer();
    chk("R7 select flipped", ext_addr, 16'h2000);
    rd16(3'd0, v); chk("R7 step before swap", v, 16'h1001);
    rd(3'd4, d); chk("R7 control select bit", {8'h00, d}, 16'h0007);
    xfer();
    chk("R7 swap back", ext_addr, 16'h1001);
    rd16(3'd2, v); chk("R7 pointer1 stepped", v, 16'h2001);
  endtask

  task automatic t_copy();
    set_ptrs(16'h0100, 16'h0200);
    wr(3'd4, 8'h06);
    for (int i = 0; i < 4; i++) begin
      chk("R7 copy source address", ext_addr, 16'h0100 + 16'(i));
      xfer();
      chk("R5 copy destination address", ext_addr, 16'h0200 + 16'(i));
      xfer();
    end
  endtask

  task automatic t_inc();
    logic [7:0] d;
    set_ptrs(16'h0050, 16'h0000);
    wr(3'd4, 8'h08);
    bump();
    chk("R8 increment ignores down direction", ext_addr, 16'h0051);
    wr(3'd4, 8'h0E);
    bump();
    chk("R8 increment with features on", ext_addr, 16'h0052);
    rd(3'd4, d); chk("R8 increment keeps select", {8'h00, d}, 16'h000E);
  endtask

  task automatic t_both();
    wr(3'd4, 8'h0A);
    xfer_done = 1'b1; inc_req = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0; inc_req = 1'b0;
    chk("R9 down step plus increment", ext_addr, 16'h0052);
    wr(3'd4, 8'h02);
    xfer_done = 1'b1; inc_req = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0; inc_req = 1'b0;
    chk("R9 up step plus increment", ext_addr, 16'h0054);
  endtask

  task automatic t_wins();
    logic [15:0] v;
    set_ptrs(16'h1234, 16'h0000);
    wr(3'd4, 8'h02);
    xfer_done = 1'b1; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h55;
    @(negedge clk);
    xfer_done = 1'b0; reg_wr = 1'b0;
    chk("R10 byte write beats step", ext_addr, 16'h1255);
    xfer_done = 1'b1; reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 8'h77;
    @(negedge clk);
    xfer_done = 1'b0; reg_wr = 1'b0;
    chk("R10 other pointer write keeps step", ext_addr, 16'h1256);
    rd16(3'd2, v); chk("R10 pointer1 high written", v, 16'h7700);
    wr(3'd4, 8'h06);
    xfer_done = 1'b1; reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 8'h06;
    @(negedge clk);
    xfer_done = 1'b0; reg_wr = 1'b0;
    chk("R10 control write beats swap", ext_addr, 16'h1257);
  endtask

  task automatic t_reset_mid();
    logic [15:0] v;
    logic [7:0] d;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset mid-run ext_addr", ext_addr, 16'h0000);
    rd(3'd4, d); chk("R1 reset mid-run control", {8'h00, d}, 16'h0000);
    rd16(3'd2, v); chk("R1 reset mid-run pointer1", v, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_step_off();
    t_step();
    t_wrap();
    t_swap();
    t_copy();
    t_inc();
    t_both();
    t_wins();
    t_reset_mid();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule